// File: doc/BRIEF.md
# Discharge-Path Protection Sequencer

This block decides when a battery pack's discharge switch may stay closed. It watches synchronous comparator flags: per-cell undervoltage and recovery flags, two sense-node levels for load current (overcurrent and short circuit), a charger-present level on that same node, and an overcharge flag from the charge-side logic. From these it drives the discharge-enable output, a standby request and the choice of sense-node pull resistor (toward the positive rail or toward the negative rail).

Three fault classes latch with their own delays, counted in ticks of an external timebase, and each has its own release path. An undervoltage fault normally parks the pack in standby, and only a charger indication ends standby. A current fault holds the pull toward the negative rail until the load is removed. Which fault came first, and whether overcharge is active, decide standby entry and the pull choice. A test input shortens every tick-counted delay except the short-circuit delay.

Top module: `dsg_guard_seq`

## Requirements
- R1: After reset, `dsg_en` is 1, `standby` is 0, and both `pull_vdd` and `pull_vss` are 0.
- R2: From the run state, if any bit of `cell_low` stays 1 for UV_DLY_TICKS sampled ticks, the outputs change on the next clock edge: `dsg_en`=0 and `pull_vdd`=1. `standby` becomes 1 unless `ovchg_active` is 1 on that edge.
- R3: While `standby` is 1, it falls only on an edge where `chg_sense` is 1. Until then, `cell_ok` has no effect and `dsg_en` stays 0.
- R4: In the undervoltage state with `standby` at 0, when all `cell_ok` bits stay 1 for REL_DLY_TICKS ticks, the block returns to run: `dsg_en`=1 and `pull_vdd`=0.
- R5: From run, `oc_hi`=1 with `ovchg_active`=0 for OC_DLY_TICKS ticks gives `dsg_en`=0 and `pull_vss`=1, and `standby` stays 0.
- R6: From run, `sc_hi`=1 for SC_DLY_TICKS ticks gives the same current-fault state. This delay ignores `test_mode`, and detection stays active while `ovchg_active` is 1.
- R7: In the current-fault state, `oc_hi`=0 held for REL_DLY_TICKS ticks returns the block to run, with `dsg_en`=1 and `pull_vss`=0.
- R8: `ovchg_active`=1 clears and blocks a pending overcurrent count in run. A current fault that has already latched is not released by `ovchg_active`.
- R9: Undervoltage detected while `ovchg_active` is 1 selects `pull_vdd` without standby, so the recovery count starts without a charger indication.
- R10: Undervoltage that matures during a current fault moves the pull from `pull_vss` to `pull_vdd` and enters standby. In the undervoltage state, `oc_hi` and `sc_hi` are ignored.
- R11: When `test_mode`=1, the undervoltage, overcurrent and release limits become max(1, delay >> TEST_SHIFT) ticks.
- R12: A pending count restarts from zero when its condition drops for one cycle before expiry. On the undervoltage tie, undervoltage wins over a current fault.
- R13: `pull_vdd` and `pull_vss` are never both 1, and `dsg_en` is 0 exactly when one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_low | input | N_CELLS | Per cell: at or below the undervoltage threshold |
| cell_ok | input | N_CELLS | Per cell: at or above the threshold plus hysteresis |
| oc_hi | input | 1 | Sense node at or above the overcurrent level |
| sc_hi | input | 1 | Sense node at or above the short-circuit level |
| chg_sense | input | 1 | Sense node at or below the charger-present level |
| ovchg_active | input | 1 | Overcharge protection currently active |
| test_mode | input | 1 | Shorten the tick-counted delays |
| tick | input | 1 | Timebase strobe, one cycle wide |
| dsg_en | output | 1 | Discharge switch enable |
| standby | output | 1 | Low-power standby request |
| pull_vdd | output | 1 | Select sense pull toward the positive rail |
| pull_vss | output | 1 | Select sense pull toward the negative rail |

## Verification
The bench builds the block with two cells and delays of 6, 4, 2 and 3 ticks, and a test shift of 1. This makes every fast limit differ from its normal one, except the short-circuit limit, which would wrongly drop to 1 if test mode reached it. With a tick every second cycle, each fault matures within about a dozen cycles. That puts fault ordering, overcharge masking, charger-only standby exit and the restart of interrupted counts within a few hundred cycles. Two windows sit between the fast and normal expiry edges, so they separate a test-mode error on either side.

// File: rtl/dsg_guard_pkg.sv
package dsg_guard_pkg;

   typedef enum logic [1:0] {
      ST_RUN = 2'd0,
      ST_UV  = 2'd1,
      ST_OC  = 2'd2
   } dsg_state_e;

   function automatic int unsigned fast_lim(input int unsigned dly, input int unsigned sh);
      int unsigned v;
      v = dly >> sh;
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dsg_delay_limits.sv
module dsg_delay_limits #(
   parameter int unsigned UV_DLY_TICKS  = 800,
   parameter int unsigned OC_DLY_TICKS  = 160,
   parameter int unsigned SC_DLY_TICKS  = 2,
   parameter int unsigned REL_DLY_TICKS = 8,
   parameter int unsigned TEST_SHIFT    = 4,
   parameter bit          TEST_EN       = 1'b1,
   parameter int unsigned CNT_W         = 10
) (
   input  logic             test_mode,
   output logic [CNT_W-1:0] uv_lim,
   output logic [CNT_W-1:0] oc_lim,
   output logic [CNT_W-1:0] sc_lim,
   output logic [CNT_W-1:0] rel_lim
);
   import dsg_guard_pkg::*;

   localparam int unsigned UV_FAST  = fast_lim(UV_DLY_TICKS, TEST_SHIFT);
   localparam int unsigned OC_FAST  = fast_lim(OC_DLY_TICKS, TEST_SHIFT);
   localparam int unsigned REL_FAST = fast_lim(REL_DLY_TICKS, TEST_SHIFT);

   if (UV_DLY_TICKS < 1 || OC_DLY_TICKS < 1 || SC_DLY_TICKS < 1 || REL_DLY_TICKS < 1) begin : g_bad_dly
      $error("dsg_delay_limits: every delay needs at least one tick");
   end
   if (TEST_SHIFT > 16) begin : g_bad_shift
      $error("dsg_delay_limits: TEST_SHIFT out of range");
   end

   // short-circuit delay never follows test mode
   assign sc_lim = CNT_W'(SC_DLY_TICKS);

   if (TEST_EN) begin : g_test
      assign uv_lim  = test_mode ? CNT_W'(UV_FAST)  : CNT_W'(UV_DLY_TICKS);
      assign oc_lim  = test_mode ? CNT_W'(OC_FAST)  : CNT_W'(OC_DLY_TICKS);
      assign rel_lim = test_mode ? CNT_W'(REL_FAST) : CNT_W'(REL_DLY_TICKS);
   end else begin : g_fixed
      logic unused_test_mode;
      assign unused_test_mode = test_mode;
      assign uv_lim  = CNT_W'(UV_DLY_TICKS);
      assign oc_lim  = CNT_W'(OC_DLY_TICKS);
      assign rel_lim = CNT_W'(REL_DLY_TICKS);
   end

endmodule

// File: rtl/dsg_delay_timer.sv
module dsg_delay_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt <= '0;
      else if (!run || clr)            cnt <= '0;
      else if (tick && (cnt < limit))  cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt >= limit);

   // R12
   tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(run)) |=> !done);

endmodule

// File: rtl/dsg_guard_seq.sv
module dsg_guard_seq #(
   parameter int unsigned N_CELLS       = 2,
   parameter int unsigned UV_DLY_TICKS  = 800,
   parameter int unsigned OC_DLY_TICKS  = 160,
   parameter int unsigned SC_DLY_TICKS  = 2,
   parameter int unsigned REL_DLY_TICKS = 8,
   parameter int unsigned TEST_SHIFT    = 4,
   parameter bit          TEST_EN       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CELLS-1:0] cell_low,
   input  logic [N_CELLS-1:0] cell_ok,
   input  logic               oc_hi,
   input  logic               sc_hi,
   input  logic               chg_sense,
   input  logic               ovchg_active,
   input  logic               test_mode,
   input  logic               tick,
   output logic               dsg_en,
   output logic               standby,
   output logic               pull_vdd,
   output logic               pull_vss
);
   import dsg_guard_pkg::*;

   localparam int unsigned MAX_DLY = max4(UV_DLY_TICKS, OC_DLY_TICKS, SC_DLY_TICKS, REL_DLY_TICKS);
   localparam int unsigned CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);
   localparam int unsigned N_TMR   = 4;
   localparam int unsigned T_UV = 0, T_OC = 1, T_SC = 2, T_REL = 3;

   if (N_CELLS < 1) begin : g_bad_cells
      $error("dsg_guard_seq: N_CELLS must be at least 1");
   end

   dsg_state_e       st_q, st_d;
   logic             sb_q, sb_d;
   logic             any_low, all_ok, moved;
   logic [N_TMR-1:0] t_run, t_done;
   logic [CNT_W-1:0] t_lim [N_TMR];

   assign any_low = |cell_low;
   assign all_ok  = &cell_ok;

   dsg_delay_limits #(
      .UV_DLY_TICKS (UV_DLY_TICKS),
      .OC_DLY_TICKS (OC_DLY_TICKS),
      .SC_DLY_TICKS (SC_DLY_TICKS),
      .REL_DLY_TICKS(REL_DLY_TICKS),
      .TEST_SHIFT   (TEST_SHIFT),
      .TEST_EN      (TEST_EN),
      .CNT_W        (CNT_W)
   ) u_lim (
      .test_mode(test_mode),
      .uv_lim   (t_lim[T_UV]),
      .oc_lim   (t_lim[T_OC]),
      .sc_lim   (t_lim[T_SC]),
      .rel_lim  (t_lim[T_REL])
   );

   // qualifying conditions for each delay
   assign t_run[T_UV]  = any_low && (st_q != ST_UV);
   assign t_run[T_OC]  = oc_hi && !ovchg_active && (st_q == ST_RUN);
   assign t_run[T_SC]  = sc_hi && (st_q == ST_RUN);
   assign t_run[T_REL] = ((st_q == ST_OC) && !oc_hi) ||
                         ((st_q == ST_UV) && !sb_q && all_ok);

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      dsg_delay_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (t_run[i]),
         .clr  (moved),
         .tick (tick),
         .limit(t_lim[i]),
         .done (t_done[i])
      );
   end

   always_comb begin
      st_d = st_q;
      sb_d = sb_q;
      unique case (st_q)
         ST_RUN: begin
            if (t_done[T_UV]) begin
               st_d = ST_UV;
               sb_d = !ovchg_active;
            end else if (t_done[T_SC] || t_done[T_OC]) begin
               st_d = ST_OC;
            end
         end
         ST_OC: begin
            if (t_done[T_UV]) begin
               st_d = ST_UV;
               sb_d = !ovchg_active;
            end else if (t_done[T_REL]) begin
               st_d = ST_RUN;
            end
         end
         ST_UV: begin
            if (sb_q) begin
               if (chg_sense) sb_d = 1'b0;
            end else if (t_done[T_REL]) begin
               st_d = ST_RUN;
               sb_d = 1'b0;
            end
         end
         default: begin
            st_d = ST_RUN;
            sb_d = 1'b0;
         end
      endcase
   end

   assign moved = (st_d != st_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_RUN;
         sb_q <= 1'b0;
      end else begin
         st_q <= st_d;
         sb_q <= sb_d;
      end
   end

   assign dsg_en   = (st_q == ST_RUN);
   assign pull_vdd = (st_q == ST_UV);
   assign pull_vss = (st_q == ST_OC);
   assign standby  = sb_q;

   // R13
   pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_vdd && pull_vss) && (dsg_en == !(pull_vdd || pull_vss)));

   // R3
   stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !chg_sense) |=> (standby && !dsg_en));

   // R9
   stby_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> pull_vdd);

   // R5
   oc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_vss) |-> ($past(sc_hi) || ($past(oc_hi) && !$past(ovchg_active))));

   // R2
   uv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_vdd) |-> ($past(any_low) && (standby == !$past(ovchg_active))));

endmodule

// File: tb/tb_dsg_guard_seq.sv
module tb_dsg_guard_seq;
   localparam int NC = 2, UVD = 6, OCD = 4, SCD = 2, RELD = 3, SH = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NC-1:0] cell_low = '0, cell_ok = '1;
   logic oc_hi = 0, sc_hi = 0, chg_sense = 0, ovchg_active = 0, test_mode = 0, tick = 0;
   logic dsg_en, standby, pull_vdd, pull_vss;

   int checks = 0, failures = 0, cyc = 0;
   string cur_req = "R1";

   // model state: 0 run, 1 undervoltage, 2 current fault
   int m_st = 0, m_sb = 0, m_uv = 0, m_oc = 0, m_sc = 0, m_rel = 0;

   always #5 clk = ~clk;

   dsg_guard_seq #(
      .N_CELLS(NC), .UV_DLY_TICKS(UVD), .OC_DLY_TICKS(OCD), .SC_DLY_TICKS(SCD),
      .REL_DLY_TICKS(RELD), .TEST_SHIFT(SH), .TEST_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cell_low(cell_low), .cell_ok(cell_ok), .oc_hi(oc_hi),
      .sc_hi(sc_hi), .chg_sense(chg_sense), .ovchg_active(ovchg_active),
      .test_mode(test_mode), .tick(tick), .dsg_en(dsg_en), .standby(standby),
      .pull_vdd(pull_vdd), .pull_vss(pull_vss)
   );

   always @(posedge clk) begin
      #2 tick = ~tick;
   end

   function automatic int fastv(int d);
      return ((d >> SH) == 0) ? 1 : (d >> SH);
   endfunction

   // behavioural reference, evaluated on each rising edge
   always @(posedge clk) begin
      int luv, loc, lsc, lrel, nst, nsb;
      bit low, ok, ruv, roc, rsc, rrel, duv, doc, dsc, drel;
      if (!rst_n) begin
         m_st = 0; m_sb = 0; m_uv = 0; m_oc = 0; m_sc = 0; m_rel = 0;
      end else begin
         luv  = test_mode ? fastv(UVD)  : UVD;
         loc  = test_mode ? fastv(OCD)  : OCD;
         lrel = test_mode ? fastv(RELD) : RELD;
         lsc  = SCD;
         low  = (cell_low != 0);
         ok   = (cell_ok == {NC{1'b1}});
         ruv  = low && m_st != 1;
         roc  = oc_hi && !ovchg_active && m_st == 0;
         rsc  = sc_hi && m_st == 0;
         rrel = (m_st == 2 && !oc_hi) || (m_st == 1 && m_sb == 0 && ok);
         duv  = ruv && m_uv >= luv;
         doc  = roc && m_oc >= loc;
         dsc  = rsc && m_sc >= lsc;
         drel = rrel && m_rel >= lrel;
         nst = m_st; nsb = m_sb;
         if (m_st != 1 && duv) begin nst = 1; nsb = ovchg_active ? 0 : 1; end
         else if (m_st == 0 && (doc || dsc)) nst = 2;
         else if (m_st == 2 && drel) nst = 0;
         else if (m_st == 1) begin
            if (m_sb == 1) begin if (chg_sense) nsb = 0; end
            else if (drel) begin nst = 0; nsb = 0; end
         end
         if (!ruv  || nst != m_st) m_uv  = 0; else if (tick && m_uv  < luv)  m_uv++;
         if (!roc  || nst != m_st) m_oc  = 0; else if (tick && m_oc  < loc)  m_oc++;
         if (!rsc  || nst != m_st) m_sc  = 0; else if (tick && m_sc  < lsc)  m_sc++;
         if (!rrel || nst != m_st) m_rel = 0; else if (tick && m_rel < lrel) m_rel++;
         m_st = nst; m_sb = nsb;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "dsg_en",   dsg_en,   m_st == 0);
         chk(cur_req, "pull_vdd", pull_vdd, m_st == 1);
         chk(cur_req, "pull_vss", pull_vss, m_st == 2);
         chk(cur_req, "standby",  standby,  m_sb == 1);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wcyc(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic probe(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   initial begin
      wcyc(3);
      chk("R1", "reset dsg_en", dsg_en, 1'b1);
      chk("R1", "reset standby", standby, 1'b0);
      chk("R1", "reset pulls", pull_vdd | pull_vss, 1'b0);
      rst_n = 1'b1;
      wcyc(4);

      // R12: interrupted undervoltage count restarts
      cur_req = "R12";
      cell_low = 2'b01; cell_ok = 2'b10; wcyc(8);
      cell_low = 2'b00; wcyc(1);
      cell_low = 2'b01; wcyc(8);
      probe(0); chk("R12", "count restarted", dsg_en, 1'b1);
      wcyc(1);

      // R2: undervoltage enters standby
      cur_req = "R2";
      cell_low = 2'b10; cell_ok = 2'b01; wcyc(20);
      probe(0);
      chk("R2", "dsg_en", dsg_en, 1'b0);
      chk("R2", "standby", standby, 1'b1);
      chk("R2", "pull_vdd", pull_vdd, 1'b1);
      wcyc(1);

      // R3: recovered cells alone do not leave standby
      cur_req = "R3";
      cell_low = '0; cell_ok = '1; wcyc(20);
      probe(0); chk("R3", "still standby", standby, 1'b1);
      chk("R3", "still off", dsg_en, 1'b0);
      wcyc(1);
      chg_sense = 1; wcyc(2); chg_sense = 0;
      cur_req = "R4"; wcyc(20);
      probe(0); chk("R4", "released", dsg_en, 1'b1);
      chk("R4", "pull off", pull_vdd, 1'b0);
      wcyc(1);

      // R5 / R7: overcurrent and release
      cur_req = "R5";
      oc_hi = 1; wcyc(20);
      probe(0); chk("R5", "pull_vss", pull_vss, 1'b1); chk("R5", "no standby", standby, 1'b0);
      wcyc(1);
      cur_req = "R7";
      oc_hi = 0; wcyc(15);
      probe(0); chk("R7", "released", dsg_en, 1'b1);
      wcyc(1);

      // R6: short circuit, fixed delay under test mode and overcharge
      cur_req = "R6";
      test_mode = 1; ovchg_active = 1; wcyc(2);
      sc_hi = 1; oc_hi = 1;
      probe(3); chk("R6", "not yet tripped", dsg_en, 1'b1);
      wcyc(10);
      probe(0); chk("R6", "tripped", pull_vss, 1'b0 | 1'b1);
      wcyc(1);
      // R8: latched fault persists under overcharge
      cur_req = "R8";
      sc_hi = 0; wcyc(10);
      probe(0); chk("R8", "latched persists", pull_vss, 1'b1);
      wcyc(1);
      oc_hi = 0; wcyc(10);
      test_mode = 0; wcyc(2);
      oc_hi = 1; wcyc(25);
      probe(0); chk("R8", "new overcurrent masked", dsg_en, 1'b1);
      wcyc(1);
      oc_hi = 0; ovchg_active = 0; wcyc(5);

      // R9: undervoltage during overcharge, no standby
      cur_req = "R9";
      ovchg_active = 1; cell_low = 2'b01; cell_ok = 2'b10; wcyc(20);
      probe(0); chk("R9", "pull_vdd", pull_vdd, 1'b1); chk("R9", "no standby", standby, 1'b0);
      wcyc(1);
      ovchg_active = 0; cell_low = '0; cell_ok = '1; wcyc(15);
      probe(0); chk("R9", "released without charger", dsg_en, 1'b1);
      wcyc(1);

      // R10: current fault then undervoltage
      cur_req = "R10";
      oc_hi = 1; wcyc(15);
      cell_low = 2'b11; cell_ok = 2'b00; wcyc(20);
      probe(0); chk("R10", "pull moved", pull_vdd, 1'b1);
      chk("R10", "neg pull off", pull_vss, 1'b0);
      chk("R10", "standby", standby, 1'b1);
      wcyc(1);
      sc_hi = 1; wcyc(12);
      probe(0); chk("R10", "current ignored", pull_vss, 1'b0);
      wcyc(1);
      sc_hi = 0; oc_hi = 0; chg_sense = 1; wcyc(2); chg_sense = 0;
      cell_low = '0; cell_ok = '1; wcyc(15);
      probe(0); chk("R10", "recovered", dsg_en, 1'b1);
      wcyc(1);

      // R11: fast overcurrent limit
      cur_req = "R11";
      test_mode = 1; wcyc(2);
      oc_hi = 1;
      probe(6); chk("R11", "fast trip", dsg_en, 1'b0);
      wcyc(1);
      oc_hi = 0; wcyc(10);
      probe(0); chk("R11", "fast release", dsg_en, 1'b1);
      wcyc(1);
      test_mode = 0; wcyc(4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule